// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 14-bit virtual address into a physical address by reading a two-level page table held in ordinary memory. A virtual address holds an 8-bit page number and a 6-bit byte offset, so pages are 64 bytes. The upper four page-number bits select one of sixteen 4-byte directory entries. The directory table starts at a root address, which software reloads on every context switch. A present directory entry names a 64-byte sub-table of sixteen leaf entries, and the lower four page-number bits select one of those entries. A directory entry with its present bit clear stands for a pruned sub-table. The walk then stops at the first level.

The leaf entry is checked for presence, user access and write permission. On success the walker sets the accessed bit, and on a write it also sets the dirty bit. When either bit changes, the updated entry is written back to memory before the result is reported. The result is a single-cycle response with either a physical address or a fault cause. Only one walk runs at a time.

Entry format, shared by both levels: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty. Bits 17:8 hold a 10-bit frame number in a leaf entry, or a 10-bit sub-table number in a directory entry. The sub-table starts at that number times 64.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1 and mem_req_valid_o and resp_valid_o are 0.
- R2: A request is taken only while req_ready_o is 1. From the accepting edge until the response, req_ready_o stays 0 and a request offered during that time is ignored. A memory request is held with a stable address until it is accepted.
- R3: The first memory read goes to root + 4 × (page number bits 7:4), using the root_i value at the accepting edge. Changing root_i later in the walk has no effect on that walk.
- R4: If the directory entry has bit 0 clear, the walk ends with resp_fault_o = 1 and resp_cause_o = 0, and no second read is made.
- R5: The second read goes to 64 × (directory bits 17:8) + 4 × (page number bits 3:0).
- R6: A leaf entry with bit 0 clear gives resp_cause_o = 1.
- R7: A user access (req_user_i = 1) to a present leaf entry with bit 2 clear gives resp_cause_o = 3. This check ranks above the write check.
- R8: A write to a present leaf entry that the access may reach, with bit 1 clear, gives resp_cause_o = 2.
- R9: On success resp_fault_o = 0 and resp_paddr_o = {leaf bits 17:8, virtual address bits 5:0}.
- R10: On success the leaf entry gains bit 5, and on a write also bit 6. It is written back to the leaf address before the response, and only when its value changed.
- R11: A walk that ends in a fault writes nothing to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_i | input | 16 | Byte address of the directory table for the running process |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vaddr_i | input | 14 | Virtual address to translate |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access comes from user mode |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_we_o | output | 1 | Memory request is a write |
| mem_req_addr_o | output | 16 | Memory byte address |
| mem_req_wdata_o | output | 32 | Entry value to write |
| mem_rsp_valid_i | input | 1 | Memory read data or write acknowledge |
| mem_rsp_rdata_i | input | 32 | Memory read data |
| resp_valid_o | output | 1 | One-cycle result strobe |
| resp_fault_o | output | 1 | Walk ended in a fault |
| resp_cause_o | output | 2 | Fault cause: 0 directory absent, 1 leaf absent, 2 read-only, 3 supervisor-only |
| resp_paddr_o | output | 16 | Translated physical address |

## Verification
Each memory step takes two cycles when the memory accepts at once and answers in the following cycle. With that memory, the response is due 3 cycles after the accepting edge for a directory fault, 5 cycles after it for a leaf result without write-back, and 7 cycles after it with write-back. For every walk the bench's reference model works out the due cycle from the table contents. At each falling edge up to that cycle it compares ready and response against the model: both stay low until the due cycle, and the full result must appear exactly then. Read addresses, the number of writes and the written entry are logged at the memory model and compared when the response arrives.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    // entry bit positions; the walker decodes these directly
    localparam int PRESENT_BIT  = 0;
    localparam int WRITE_BIT    = 1;
    localparam int USER_BIT     = 2;
    localparam int ACCESSED_BIT = 5;
    localparam int DIRTY_BIT    = 6;
    localparam int NUM_LSB      = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_LEAF_REQ,
        ST_LEAF_WAIT,
        ST_WB_REQ,
        ST_WB_WAIT
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_DIR_ABSENT  = 2'd0,
        FLT_LEAF_ABSENT = 2'd1,
        FLT_READ_ONLY   = 2'd2,
        FLT_PRIV        = 2'd3
    } fault_e;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
    parameter int MEM_AW = 16,
    parameter int OFF_W  = 6,
    parameter int DIR_W  = 4,
    parameter int TBL_W  = 4,
    localparam int NUM_W = MEM_AW - OFF_W
) (
    input  logic [MEM_AW-1:0] root_i,
    input  logic [DIR_W-1:0]  req_vpn_hi_i,
    input  logic [TBL_W-1:0]  walk_vpn_lo_i,
    input  logic [NUM_W-1:0]  sub_num_i,
    output logic [MEM_AW-1:0] dir_addr_o,
    output logic [MEM_AW-1:0] leaf_addr_o
);

    // 4-byte entries: index scaled by 4
    always_comb begin
        dir_addr_o  = root_i + {{(MEM_AW-DIR_W-2){1'b0}}, req_vpn_hi_i, 2'b00};
        leaf_addr_o = {sub_num_i, {OFF_W{1'b0}}}
                    + {{(MEM_AW-TBL_W-2){1'b0}}, walk_vpn_lo_i, 2'b00};
    end

endmodule

// File: rtl/pt_leaf_check.sv
module pt_leaf_check
    import pt_walker_pkg::*;
#(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] entry_i,
    input  logic             is_write_i,
    input  logic             is_user_i,
    output logic             ok_o,
    output fault_e           cause_o,
    output logic [PTE_W-1:0] new_entry_o,
    output logic             needs_wb_o
);

    always_comb begin
        ok_o    = 1'b0;
        cause_o = FLT_LEAF_ABSENT;
        // ranking: presence, then privilege, then write permission
        if (!entry_i[PRESENT_BIT]) begin
            cause_o = FLT_LEAF_ABSENT;
        end else if (is_user_i && !entry_i[USER_BIT]) begin
            cause_o = FLT_PRIV;
        end else if (is_write_i && !entry_i[WRITE_BIT]) begin
            cause_o = FLT_READ_ONLY;
        end else begin
            ok_o = 1'b1;
        end

        new_entry_o               = entry_i;
        new_entry_o[ACCESSED_BIT] = 1'b1;
        if (is_write_i) begin
            new_entry_o[DIRTY_BIT] = 1'b1;
        end
        needs_wb_o = ok_o && (new_entry_o != entry_i);
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W   = 14,
    parameter int OFF_W  = 6,
    parameter int DIR_W  = 4,
    parameter int MEM_AW = 16,
    parameter int PTE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_AW-1:0] root_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [VA_W-1:0]   req_vaddr_i,
    input  logic              req_write_i,
    input  logic              req_user_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic              mem_req_we_o,
    output logic [MEM_AW-1:0] mem_req_addr_o,
    output logic [PTE_W-1:0]  mem_req_wdata_o,
    input  logic              mem_rsp_valid_i,
    input  logic [PTE_W-1:0]  mem_rsp_rdata_i,
    output logic              resp_valid_o,
    output logic              resp_fault_o,
    output logic [1:0]        resp_cause_o,
    output logic [MEM_AW-1:0] resp_paddr_o
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int TBL_W = VPN_W - DIR_W;
    localparam int NUM_W = MEM_AW - OFF_W;

    typedef struct packed {
        walk_state_e       state;
        logic [VA_W-1:0]   vaddr;
        logic              wr;
        logic              usr;
        logic [MEM_AW-1:0] ptr;
        logic [PTE_W-1:0]  entry;
        logic [NUM_W-1:0]  pfn;
        logic              resp_valid;
        logic              fault;
        fault_e            cause;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [MEM_AW-1:0] dir_addr, leaf_addr;
    logic              leaf_ok, leaf_wb;
    fault_e            leaf_cause;
    logic [PTE_W-1:0]  leaf_new;

    pt_walk_addr #(
        .MEM_AW (MEM_AW),
        .OFF_W  (OFF_W),
        .DIR_W  (DIR_W),
        .TBL_W  (TBL_W)
    ) u_addr (
        .root_i        (root_i),
        .req_vpn_hi_i  (req_vaddr_i[VA_W-1 -: DIR_W]),
        .walk_vpn_lo_i (r_q.vaddr[OFF_W +: TBL_W]),
        .sub_num_i     (mem_rsp_rdata_i[NUM_LSB +: NUM_W]),
        .dir_addr_o    (dir_addr),
        .leaf_addr_o   (leaf_addr)
    );

    pt_leaf_check #(
        .PTE_W (PTE_W)
    ) u_check (
        .entry_i     (mem_rsp_rdata_i),
        .is_write_i  (r_q.wr),
        .is_user_i   (r_q.usr),
        .ok_o        (leaf_ok),
        .cause_o     (leaf_cause),
        .new_entry_o (leaf_new),
        .needs_wb_o  (leaf_wb)
    );

    always_comb begin
        r_d            = r_q;
        r_d.resp_valid = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    r_d.vaddr = req_vaddr_i;
                    r_d.wr    = req_write_i;
                    r_d.usr   = req_user_i;
                    r_d.ptr   = dir_addr;   // root sampled here only
                    r_d.state = ST_DIR_REQ;
                end
            end
            ST_DIR_REQ: begin
                if (mem_req_ready_i) r_d.state = ST_DIR_WAIT;
            end
            ST_DIR_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (!mem_rsp_rdata_i[PRESENT_BIT]) begin
                        r_d.resp_valid = 1'b1;
                        r_d.fault      = 1'b1;
                        r_d.cause      = FLT_DIR_ABSENT;
                        r_d.pfn        = '0;
                        r_d.state      = ST_IDLE;
                    end else begin
                        r_d.ptr   = leaf_addr;
                        r_d.state = ST_LEAF_REQ;
                    end
                end
            end
            ST_LEAF_REQ: begin
                if (mem_req_ready_i) r_d.state = ST_LEAF_WAIT;
            end
            ST_LEAF_WAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.cause = leaf_cause;
                    if (!leaf_ok) begin
                        r_d.resp_valid = 1'b1;
                        r_d.fault      = 1'b1;
                        r_d.pfn        = '0;
                        r_d.state      = ST_IDLE;
                    end else begin
                        r_d.fault = 1'b0;
                        r_d.pfn   = mem_rsp_rdata_i[NUM_LSB +: NUM_W];
                        r_d.entry = leaf_new;
                        if (leaf_wb) begin
                            r_d.state = ST_WB_REQ;
                        end else begin
                            r_d.resp_valid = 1'b1;
                            r_d.state      = ST_IDLE;
                        end
                    end
                end
            end
            ST_WB_REQ: begin
                if (mem_req_ready_i) r_d.state = ST_WB_WAIT;
            end
            ST_WB_WAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.resp_valid = 1'b1;
                    r_d.state      = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= walk_regs_t'('0);
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready_o     = (r_q.state == ST_IDLE);
    assign mem_req_valid_o = (r_q.state == ST_DIR_REQ) || (r_q.state == ST_LEAF_REQ)
                          || (r_q.state == ST_WB_REQ);
    assign mem_req_we_o    = (r_q.state == ST_WB_REQ);
    assign mem_req_addr_o  = r_q.ptr;
    assign mem_req_wdata_o = r_q.entry;
    assign resp_valid_o    = r_q.resp_valid;
    assign resp_fault_o    = r_q.fault;
    assign resp_cause_o    = r_q.cause;
    assign resp_paddr_o    = {r_q.pfn, r_q.vaddr[OFF_W-1:0]};

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walker_pkg::*;
#(
    parameter int MEM_AW = 16,
    parameter int PTE_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic              mem_req_we_o,
    input logic [MEM_AW-1:0] mem_req_addr_o,
    input logic [PTE_W-1:0]  mem_req_wdata_o,
    input logic              resp_valid_o
);

    // R2: an idle walker issues no memory traffic
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !mem_req_valid_o);

    // R2: an accepted request makes the walker busy
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o |=> !req_ready_o);

    // R2: a stalled memory request is held unchanged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=>
            mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o));

    // R10: every write-back carries the accessed bit
    p_wb_accessed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_we_o |-> mem_req_wdata_o[ACCESSED_BIT]);

    // R2: one walk at a time, so a response never lasts two cycles
    p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |=> !resp_valid_o);

endmodule

bind pt_walker pt_walker_chk #(.MEM_AW(MEM_AW), .PTE_W(PTE_W)) u_chk (.*);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] root_i = '0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [13:0] req_vaddr_i = '0;
    logic        req_write_i = 1'b0;
    logic        req_user_i = 1'b0;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b1;
    logic        mem_req_we_o;
    logic [15:0] mem_req_addr_o;
    logic [31:0] mem_req_wdata_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_rdata_i = '0;
    logic        resp_valid_o;
    logic        resp_fault_o;
    logic [1:0]  resp_cause_o;
    logic [15:0] resp_paddr_o;

    always #2 clk = ~clk;

    pt_walker u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] mem [int];
    logic [15:0] rd_log [$];
    int          wr_cnt = 0;

    function automatic logic [31:0] mem_rd(input int a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: accepts at once, answers one cycle later
    initial begin
        bit          pend = 1'b0;
        logic [31:0] pdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            if (pend) begin
                mem_rsp_valid_i = 1'b1;
                mem_rsp_rdata_i = pdata;
                pend = 1'b0;
            end else if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
                pend = 1'b1;
                if (mem_req_we_o) begin
                    mem[int'(mem_req_addr_o)] = mem_req_wdata_o;
                    wr_cnt++;
                    pdata = '0;
                end else begin
                    pdata = mem_rd(int'(mem_req_addr_o));
                    rd_log.push_back(mem_req_addr_o);
                end
            end
        end
    end

    // one walk, compared against the behavioural model every cycle
    task automatic walk(input logic [7:0] vpn, input logic [5:0] off, input bit wr,
                        input bit usr, input logic [15:0] root, input bit disturb);
        int          dir_a, leaf_a, lat, exp_rd, exp_wr;
        logic [31:0] d, l, nv;
        bit          flt;
        int          cause;
        logic [15:0] pa;
        dir_a  = int'(root) + 4 * int'(vpn[7:4]);
        d      = mem_rd(dir_a);
        leaf_a = 0; l = '0; nv = '0; pa = '0; flt = 1'b0; cause = 0; exp_wr = 0;
        if (!d[0]) begin
            flt = 1'b1; cause = 0; lat = 3; exp_rd = 1;
        end else begin
            leaf_a = 64 * int'(d[17:8]) + 4 * int'(vpn[3:0]);
            l      = mem_rd(leaf_a);
            exp_rd = 2; lat = 5;
            if (!l[0])              begin flt = 1'b1; cause = 1; end
            else if (usr && !l[2])  begin flt = 1'b1; cause = 3; end
            else if (wr && !l[1])   begin flt = 1'b1; cause = 2; end
            else begin
                nv = l | 32'h20 | (wr ? 32'h40 : 32'h0);
                pa = {l[17:8], off};
                if (nv != l) begin exp_wr = 1; lat = 7; end
            end
        end

        rd_log.delete();
        wr_cnt = 0;
        @(negedge clk);
        chk(req_ready_o === 1'b1, "R2 ready before request", 32'(req_ready_o), 1);
        req_valid_i = 1'b1; req_vaddr_i = {vpn, off}; req_write_i = wr;
        req_user_i = usr; root_i = root;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (disturb) begin
                    req_vaddr_i = {~vpn, off};       // must be ignored (R2)
                    root_i      = root ^ 16'h3000;   // must be ignored (R3)
                end else begin
                    req_valid_i = 1'b0;
                end
            end
            if (k < lat) begin
                if (req_ready_o !== 1'b0 || resp_valid_o !== 1'b0) begin
                    chk(1'b0, "R2 busy window", {30'd0, req_ready_o, resp_valid_o}, 0);
                end
            end else begin
                req_valid_i = 1'b0;
                chk(resp_valid_o === 1'b1, "R2 response due cycle", 32'(resp_valid_o), 1);
                chk(resp_fault_o === flt, "R4/R6/R7/R8 fault flag", 32'(resp_fault_o), 32'(flt));
                if (flt) begin
                    chk(int'(resp_cause_o) == cause, "R4 R6 R7 R8 cause",
                        32'(resp_cause_o), 32'(cause));
                    chk(wr_cnt == 0, "R11 no write on fault", 32'(wr_cnt), 0);
                end else begin
                    chk(resp_paddr_o === pa, "R9 paddr", 32'(resp_paddr_o), 32'(pa));
                    chk(wr_cnt == exp_wr, "R10 write-back count", 32'(wr_cnt), 32'(exp_wr));
                    if (exp_wr == 1)
                        chk(mem_rd(leaf_a) === nv, "R10 written entry", mem_rd(leaf_a), nv);
                end
                chk(rd_log.size() == exp_rd, "R4 R5 read count", 32'(rd_log.size()), 32'(exp_rd));
                if (rd_log.size() >= 1)
                    chk(int'(rd_log[0]) == dir_a, "R3 directory address",
                        32'(rd_log[0]), 32'(dir_a));
                if (rd_log.size() >= 2)
                    chk(int'(rd_log[1]) == leaf_a, "R5 leaf address",
                        32'(rd_log[1]), 32'(leaf_a));
            end
        end
        if (disturb) begin
            @(negedge clk);
            chk(req_ready_o === 1'b1 && mem_req_valid_o === 1'b0,
                "R2 held request not started", 32'(mem_req_valid_o), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // process A tables, root 0x0400
        mem[32'h0404] = (32'h020 << 8) | 32'h1;          // sub-table at 0x0800
        mem[32'h0408] = (32'h030 << 8);                  // number set, not present
        mem[32'h0808] = (32'h155 << 8) | 32'h7;          // P W U
        mem[32'h0810] = (32'h0AA << 8) | 32'h3;          // supervisor only
        mem[32'h0814] = (32'h0C3 << 8) | 32'h5;          // user read-only
        mem[32'h0818] = (32'h07F << 8) | 32'h67;         // A and D already set
        mem[32'h081C] = (32'h044 << 8) | 32'h1;          // supervisor read-only
        // process B tables, root 0x2000
        mem[32'h2004] = (32'h090 << 8) | 32'h1;          // sub-table at 0x2400
        mem[32'h2408] = (32'h3E1 << 8) | 32'h27;         // P W U A

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready_o === 1'b1, "R1 ready after reset", 32'(req_ready_o), 1);
        chk(mem_req_valid_o === 1'b0, "R1 no memory request", 32'(mem_req_valid_o), 0);
        chk(resp_valid_o === 1'b0, "R1 no response", 32'(resp_valid_o), 0);

        walk(8'h12, 6'h05, 1'b0, 1'b1, 16'h0400, 1'b0); // R10 accessed set, write-back
        walk(8'h12, 6'h3F, 1'b0, 1'b1, 16'h0400, 1'b0); // R10 unchanged, no write
        walk(8'h12, 6'h00, 1'b1, 1'b1, 16'h0400, 1'b0); // R10 dirty set
        walk(8'h30, 6'h01, 1'b0, 1'b0, 16'h0400, 1'b0); // R4 empty directory entry
        walk(8'h20, 6'h01, 1'b1, 1'b1, 16'h0400, 1'b0); // R4 non-present with number
        walk(8'h13, 6'h02, 1'b0, 1'b0, 16'h0400, 1'b0); // R6 leaf absent
        walk(8'h14, 6'h03, 1'b0, 1'b1, 16'h0400, 1'b0); // R7 user on supervisor page
        walk(8'h14, 6'h04, 1'b1, 1'b0, 16'h0400, 1'b0); // R9 supervisor write ok
        walk(8'h15, 6'h05, 1'b1, 1'b1, 16'h0400, 1'b0); // R8 read-only
        walk(8'h15, 6'h06, 1'b0, 1'b1, 16'h0400, 1'b0); // R9 user read ok
        walk(8'h17, 6'h07, 1'b1, 1'b1, 16'h0400, 1'b0); // R7 ranks above R8
        walk(8'h17, 6'h08, 1'b1, 1'b0, 16'h0400, 1'b0); // R8 supervisor on read-only
        walk(8'h16, 6'h09, 1'b1, 1'b1, 16'h0400, 1'b0); // R10 A and D set, no write
        walk(8'h12, 6'h0A, 1'b0, 1'b1, 16'h2000, 1'b0); // R3 context switch to root B
        walk(8'h12, 6'h0B, 1'b0, 1'b1, 16'h0400, 1'b1); // R2 R3 disturbance ignored

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule